// File: doc/BRIEF.md
# I2C Transaction Sequencer with Repeated Start

This block sits above a byte-level I2C engine and decides the order of bus commands for a whole transaction. Software sets an operation type, an address byte, one or two lengths, a transaction count and a restart policy, then pulses a start strobe. The sequencer issues START, the address byte, the data bytes and then either a repeated START or a STOP. It handshakes with the engine one command at a time and raises pulses for completion, for an acknowledge error and for a paused restart point.

Three operation types are supported. A plain write sends bytes taken from a transmit byte input. A plain read requests bytes from the engine and marks the last one, so that the engine answers it with a master NACK. A combined write-then-read runs exactly two transactions: the write phase first, then the read phase with the direction bit of the address forced to read. A re-trigger mode runs one transaction per start strobe. When more work is flagged it stops short of STOP and waits with the bus held, so that the next strobe continues with a repeated START.

The state machine has seven states. IDLE waits for a strobe. START issues START or repeated START. ADDR sends the address byte. DATA moves the data bytes. END decides what follows the transaction. STOP issues STOP. PAUSE holds the bus until the next strobe. The transitions are: IDLE->START on a strobe; START->ADDR on acknowledge; ADDR->DATA, or ADDR->END when the length is zero; DATA->END after the final byte; ADDR/DATA->STOP on a NACK; END->START (repeated start), END->STOP (either final or followed by a fresh start), END->PAUSE; STOP->START or STOP->IDLE; PAUSE->START on a strobe.

Top module: `i2c_xact_seq`

## Requirements
- R1: After reset and whenever idle, `busy` is 0, `cmd_valid` is 0 and no event pulse (`ev_done`, `ev_ackerr`, `ev_rs_done`) is high.
- R2: A strobe (`start_go`=1 while idle) with `op_mode` 0 or 1 (write) issues START (`cmd_op`=0), then WRITE (`cmd_op`=3) of `addr_byte` exactly as given, then `len_wr` WRITE commands carrying `tx_byte`, then STOP (`cmd_op`=2). `tx_take` pulses in the cycle each data byte is acknowledged. `ev_done` pulses in the cycle STOP is acknowledged. A length of 0 sends the address only.
- R3: With `op_mode`=2 (read) the address byte is sent as given, followed by `len_wr` READ commands (`cmd_op`=4) with `cmd_byte`=0. `cmd_last`=1 is set on the final READ only.
- R4: For write and read operations, `xact_count` transactions are run back to back (0 counts as 1), each repeating the address byte. Between them the sequencer issues a repeated START (`cmd_op`=1) when `ctrl_rs`=1, and STOP followed by START when `ctrl_rs`=0.
- R5: With `op_mode`=3 (combined) exactly two transactions run, whatever `xact_count` is. The first writes `len_wr` bytes. The second sends `addr_byte` with bit 0 forced to 1 and reads min(`len_rd`, 31) bytes. The junction between them follows `ctrl_rs` as in R4.
- R6: An acknowledge with `eng_nack`=1 on the address byte or on a written data byte pulses `ev_ackerr` in that cycle. The sequencer then sends no further byte, issues STOP, pulses `ev_done` when STOP is acknowledged, and returns to idle. No `ev_rs_done` pulse occurs in that transaction, and at most one event pulse is high in any cycle.
- R7: A strobe with `start_multi`=1 and a non-combined operation runs a single transaction. If `start_more`=1 it pulses `ev_rs_done`, issues no STOP and waits with `busy`=1. The next strobe samples `addr_byte`, `len_wr` and `start_more` again and begins with a repeated START. A transaction whose strobe had `start_more`=0 ends with STOP and `ev_done`.
- R8: `start_go` is ignored while a transaction is running (any state other than idle or paused). In idle, `start_multi` or `start_more` without `start_go` starts nothing.
- R9: Once `cmd_valid` is raised, it stays high with `cmd_op` and `cmd_byte` unchanged until `eng_done` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_go | input | 1 | Start strobe |
| start_multi | input | 1 | Re-trigger mode for this strobe |
| start_more | input | 1 | Further transactions follow this one |
| op_mode | input | 2 | 0/1 write, 2 read, 3 combined write-then-read |
| ctrl_rs | input | 1 | Repeated START (1) or STOP+START (0) between transactions |
| addr_byte | input | 8 | Address in bits 7:1, direction in bit 0 |
| len_wr | input | 8 | First-phase (or only) length in bytes |
| len_rd | input | 8 | Read-phase length in combined mode |
| xact_count | input | 8 | Transactions for write/read operations |
| tx_byte | input | 8 | Next byte to transmit |
| eng_done | input | 1 | Engine acknowledge of the current command |
| eng_nack | input | 1 | Slave NACK, valid with eng_done |
| cmd_valid | output | 1 | Command request to the engine |
| cmd_op | output | 3 | 0 START, 1 RSTART, 2 STOP, 3 WRITE, 4 READ |
| cmd_byte | output | 8 | Byte for WRITE commands, 0 otherwise |
| cmd_last | output | 1 | Final READ of the phase |
| tx_take | output | 1 | Transmit byte consumed |
| busy | output | 1 | Sequencer not idle |
| ev_done | output | 1 | Transaction sequence complete |
| ev_ackerr | output | 1 | Slave did not acknowledge |
| ev_rs_done | output | 1 | Paused at a restart point |

## Verification
The hazardous coincidence is a NACK on the last data byte of a transaction. The end of the transaction and the acknowledge error then fall in the same acknowledge cycle, and the error has to win over the move to the next transaction or to the pause. The bench provokes it in re-trigger mode with more work flagged, by NACKing the final write byte. It is judged by the command stream: the ack error must come right after that byte, then STOP and completion, with no restart event and no further byte. A second coincidence is a start strobe arriving mid-transaction; the bench checks that the command stream is identical to the same run without that strobe.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

    typedef enum logic [2:0] {
        CMD_START  = 3'd0,
        CMD_RSTART = 3'd1,
        CMD_STOP   = 3'd2,
        CMD_WRITE  = 3'd3,
        CMD_READ   = 3'd4
    } seq_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_DATA,
        ST_END,
        ST_STOP,
        ST_PAUSE
    } seq_state_e;

    localparam logic [1:0] OPM_READ = 2'd2;
    localparam logic [1:0] OPM_WRRD = 2'd3;

endpackage

// File: rtl/i2c_seq_down_cnt.sv
module i2c_seq_down_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_zero,
    output logic         is_one
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    assign is_zero = (cnt_q == '0);
    assign is_one  = (cnt_q == W'(1));

endmodule

// File: rtl/i2c_seq_phase_cfg.sv
module i2c_seq_phase_cfg
    import i2c_seq_pkg::*;
#(
    parameter int LEN_W   = 8,
    parameter int RD2_MAX = 31
) (
    input  logic [1:0]       op_q,
    input  logic             phase2,
    input  logic [7:0]       addr_q,
    input  logic [LEN_W-1:0] len_wr_q,
    input  logic [LEN_W-1:0] len_rd_q,
    output logic             phase_read,
    output logic [LEN_W-1:0] phase_len,
    output logic [7:0]       addr_eff
);

    localparam logic [LEN_W-1:0] RD2_LIM = LEN_W'(RD2_MAX);

    logic combined;
    logic second_read;
    logic [LEN_W-1:0] rd_clamped;

    assign combined    = (op_q == OPM_WRRD);
    assign second_read = combined && phase2;
    assign rd_clamped  = (len_rd_q > RD2_LIM) ? RD2_LIM : len_rd_q;

    always_comb begin
        if (combined) begin
            phase_read = phase2;
        end else begin
            phase_read = (op_q == OPM_READ);
        end
        phase_len = second_read ? rd_clamped : len_wr_q;
        addr_eff  = second_read ? {addr_q[7:1], 1'b1} : addr_q;
    end

endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
    import i2c_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_go,
    input  logic     multi_q,
    input  logic     more_q,
    input  logic     combined_q,
    input  logic     rs_q,
    input  logic     phase_read,
    input  logic     byte_zero,
    input  logic     byte_one,
    input  logic     xact_one,
    input  logic     eng_done,
    input  logic     eng_nack,
    output logic     cmd_valid,
    output seq_cmd_e cmd_op,
    output logic     cmd_last,
    output logic     sel_addr,
    output logic     sel_tx,
    output logic     tx_take,
    output logic     cfg_load,
    output logic     cfg_reload,
    output logic     byte_load,
    output logic     byte_dec,
    output logic     xact_dec,
    output logic     phase2,
    output logic     busy,
    output logic     ev_done,
    output logic     ev_ackerr,
    output logic     ev_rs_done
);

    seq_state_e state_q, state_d;
    logic       rs_next_q, rs_next_d;
    logic       cont_q, cont_d;
    logic       phase2_q, phase2_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rs_next_q <= 1'b0;
            cont_q    <= 1'b0;
            phase2_q  <= 1'b0;
        end else begin
            state_q   <= state_d;
            rs_next_q <= rs_next_d;
            cont_q    <= cont_d;
            phase2_q  <= phase2_d;
        end
    end

    // transitions
    always_comb begin
        state_d   = state_q;
        rs_next_d = rs_next_q;
        cont_d    = cont_q;
        phase2_d  = phase2_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_go) begin
                    state_d   = ST_START;
                    rs_next_d = 1'b0;
                    cont_d    = 1'b0;
                    phase2_d  = 1'b0;
                end
            end
            ST_START: begin
                if (eng_done) begin
                    state_d = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (eng_done) begin
                    if (eng_nack) begin
                        state_d = ST_STOP;
                        cont_d  = 1'b0;
                    end else if (byte_zero) begin
                        state_d = ST_END;
                    end else begin
                        state_d = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (eng_done) begin
                    if (!phase_read && eng_nack) begin
                        state_d = ST_STOP;
                        cont_d  = 1'b0;
                    end else if (byte_one) begin
                        state_d = ST_END;
                    end
                end
            end
            ST_END: begin
                if (multi_q) begin
                    if (more_q) begin
                        state_d   = ST_PAUSE;
                        rs_next_d = 1'b1;
                    end else begin
                        state_d = ST_STOP;
                        cont_d  = 1'b0;
                    end
                end else if (!xact_one) begin
                    if (combined_q) begin
                        phase2_d = 1'b1;
                    end
                    if (rs_q) begin
                        state_d   = ST_START;
                        rs_next_d = 1'b1;
                    end else begin
                        state_d   = ST_STOP;
                        cont_d    = 1'b1;
                        rs_next_d = 1'b0;
                    end
                end else begin
                    state_d = ST_STOP;
                    cont_d  = 1'b0;
                end
            end
            ST_STOP: begin
                if (eng_done) begin
                    state_d = cont_q ? ST_START : ST_IDLE;
                end
            end
            ST_PAUSE: begin
                if (start_go) begin
                    state_d = ST_START;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_valid  = 1'b0;
        cmd_op     = CMD_START;
        cmd_last   = 1'b0;
        sel_addr   = 1'b0;
        sel_tx     = 1'b0;
        tx_take    = 1'b0;
        cfg_load   = 1'b0;
        cfg_reload = 1'b0;
        byte_load  = 1'b0;
        byte_dec   = 1'b0;
        xact_dec   = 1'b0;
        ev_done    = 1'b0;
        ev_ackerr  = 1'b0;
        ev_rs_done = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cfg_load = start_go;
            end
            ST_START: begin
                cmd_valid = 1'b1;
                cmd_op    = rs_next_q ? CMD_RSTART : CMD_START;
                byte_load = eng_done;
            end
            ST_ADDR: begin
                cmd_valid = 1'b1;
                cmd_op    = CMD_WRITE;
                sel_addr  = 1'b1;
                ev_ackerr = eng_done && eng_nack;
            end
            ST_DATA: begin
                cmd_valid = 1'b1;
                cmd_op    = phase_read ? CMD_READ : CMD_WRITE;
                sel_tx    = !phase_read;
                cmd_last  = phase_read && byte_one;
                byte_dec  = eng_done;
                tx_take   = eng_done && !phase_read;
                ev_ackerr = eng_done && eng_nack && !phase_read;
            end
            ST_END: begin
                xact_dec   = !multi_q && !xact_one;
                ev_rs_done = multi_q && more_q;
            end
            ST_STOP: begin
                cmd_valid = 1'b1;
                cmd_op    = CMD_STOP;
                ev_done   = eng_done && !cont_q;
            end
            ST_PAUSE: begin
                cfg_reload = start_go;
            end
            default: begin
                cmd_valid = 1'b0;
            end
        endcase
    end

    assign phase2 = phase2_q;
    assign busy   = (state_q != ST_IDLE);

endmodule

// File: rtl/i2c_xact_seq.sv
module i2c_xact_seq
    import i2c_seq_pkg::*;
#(
    parameter int LEN_W   = 8,
    parameter int CNT_W   = 8,
    parameter int RD2_MAX = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_go,
    input  logic             start_multi,
    input  logic             start_more,
    input  logic [1:0]       op_mode,
    input  logic             ctrl_rs,
    input  logic [7:0]       addr_byte,
    input  logic [LEN_W-1:0] len_wr,
    input  logic [LEN_W-1:0] len_rd,
    input  logic [CNT_W-1:0] xact_count,
    input  logic [7:0]       tx_byte,
    input  logic             eng_done,
    input  logic             eng_nack,
    output logic             cmd_valid,
    output logic [2:0]       cmd_op,
    output logic [7:0]       cmd_byte,
    output logic             cmd_last,
    output logic             tx_take,
    output logic             busy,
    output logic             ev_done,
    output logic             ev_ackerr,
    output logic             ev_rs_done
);

    logic [1:0]       op_q;
    logic [7:0]       addr_q;
    logic [LEN_W-1:0] len_wr_q;
    logic [LEN_W-1:0] len_rd_q;
    logic             rs_q;
    logic             multi_q;
    logic             more_q;

    logic             cfg_load, cfg_reload;
    logic             byte_load, byte_dec, xact_dec;
    logic             byte_zero, byte_one, xact_one, xact_zero_unused;
    logic             phase2, phase_read;
    logic             sel_addr, sel_tx;
    logic [LEN_W-1:0] phase_len;
    logic [7:0]       addr_eff;
    logic [CNT_W-1:0] xact_init;
    seq_cmd_e         cmd_op_e;
    logic             combined_q;

    assign combined_q = (op_q == OPM_WRRD);

    always_comb begin
        if (op_mode == OPM_WRRD) begin
            xact_init = CNT_W'(2);
        end else if (xact_count == '0) begin
            xact_init = CNT_W'(1);
        end else begin
            xact_init = xact_count;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= '0;
            addr_q   <= '0;
            len_wr_q <= '0;
            len_rd_q <= '0;
            rs_q     <= 1'b0;
            multi_q  <= 1'b0;
            more_q   <= 1'b0;
        end else if (cfg_load) begin
            op_q     <= op_mode;
            addr_q   <= addr_byte;
            len_wr_q <= len_wr;
            len_rd_q <= len_rd;
            rs_q     <= ctrl_rs;
            multi_q  <= start_multi && (op_mode != OPM_WRRD);
            more_q   <= start_more;
        end else if (cfg_reload) begin
            addr_q   <= addr_byte;
            len_wr_q <= len_wr;
            more_q   <= start_more;
        end
    end

    i2c_seq_phase_cfg #(
        .LEN_W   (LEN_W),
        .RD2_MAX (RD2_MAX)
    ) u_phase (
        .op_q       (op_q),
        .phase2     (phase2),
        .addr_q     (addr_q),
        .len_wr_q   (len_wr_q),
        .len_rd_q   (len_rd_q),
        .phase_read (phase_read),
        .phase_len  (phase_len),
        .addr_eff   (addr_eff)
    );

    i2c_seq_down_cnt #(.W(LEN_W)) u_byte_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (byte_load),
        .load_val (phase_len),
        .dec      (byte_dec),
        .is_zero  (byte_zero),
        .is_one   (byte_one)
    );

    i2c_seq_down_cnt #(.W(CNT_W)) u_xact_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .load_val (xact_init),
        .dec      (xact_dec),
        .is_zero  (xact_zero_unused),
        .is_one   (xact_one)
    );

    i2c_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_go   (start_go),
        .multi_q    (multi_q),
        .more_q     (more_q),
        .combined_q (combined_q),
        .rs_q       (rs_q),
        .phase_read (phase_read),
        .byte_zero  (byte_zero),
        .byte_one   (byte_one),
        .xact_one   (xact_one || xact_zero_unused),
        .eng_done   (eng_done),
        .eng_nack   (eng_nack),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op_e),
        .cmd_last   (cmd_last),
        .sel_addr   (sel_addr),
        .sel_tx     (sel_tx),
        .tx_take    (tx_take),
        .cfg_load   (cfg_load),
        .cfg_reload (cfg_reload),
        .byte_load  (byte_load),
        .byte_dec   (byte_dec),
        .xact_dec   (xact_dec),
        .phase2     (phase2),
        .busy       (busy),
        .ev_done    (ev_done),
        .ev_ackerr  (ev_ackerr),
        .ev_rs_done (ev_rs_done)
    );

    assign cmd_op = cmd_op_e;

    always_comb begin
        if (sel_addr) begin
            cmd_byte = addr_eff;
        end else if (sel_tx) begin
            cmd_byte = tx_byte;
        end else begin
            cmd_byte = 8'h00;
        end
    end

endmodule

// File: rtl/i2c_xact_seq_chk.sv
module i2c_xact_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic [7:0] cmd_byte,
    input logic       eng_done,
    input logic       tx_take,
    input logic       busy,
    input logic       ev_done,
    input logic       ev_ackerr,
    input logic       ev_rs_done
);

    AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid && !ev_done && !ev_ackerr && !ev_rs_done); // R1

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !eng_done |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte)); // R9

    AST_ACKERR_THEN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ackerr |=> cmd_valid && cmd_op == 3'd2); // R6

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_done, ev_ackerr, ev_rs_done})); // R6

    AST_TAKE_ON_WRITE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |-> cmd_valid && cmd_op == 3'd3 && eng_done); // R2

    AST_DONE_ON_STOP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |-> cmd_valid && cmd_op == 3'd2 && eng_done); // R2

    AST_PAUSE_HOLDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rs_done |=> !cmd_valid && busy); // R7

endmodule

bind i2c_xact_seq i2c_xact_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_byte   (cmd_byte),
    .eng_done   (eng_done),
    .tx_take    (tx_take),
    .busy       (busy),
    .ev_done    (ev_done),
    .ev_ackerr  (ev_ackerr),
    .ev_rs_done (ev_rs_done)
);

// File: tb/i2c_xact_seq_bench.sv
`timescale 1ns/1ps
module i2c_xact_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_go = 1'b0, start_multi = 1'b0, start_more = 1'b0;
    logic [1:0] op_mode = 2'd1;
    logic       ctrl_rs = 1'b0;
    logic [7:0] addr_byte = 8'hA4, len_wr = 8'd1, len_rd = 8'd1, xact_count = 8'd1;
    logic [7:0] tx_byte = 8'hA0;
    logic       eng_done = 1'b0, eng_nack = 1'b0;
    logic       cmd_valid, cmd_last, tx_take, busy, ev_done, ev_ackerr, ev_rs_done;
    logic [2:0] cmd_op;
    logic [7:0] cmd_byte;

    always #2 clk = ~clk;

    i2c_xact_seq u_i2c_xact_seq (
        .clk(clk), .rst_n(rst_n), .start_go(start_go), .start_multi(start_multi),
        .start_more(start_more), .op_mode(op_mode), .ctrl_rs(ctrl_rs),
        .addr_byte(addr_byte), .len_wr(len_wr), .len_rd(len_rd),
        .xact_count(xact_count), .tx_byte(tx_byte), .eng_done(eng_done),
        .eng_nack(eng_nack), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_byte(cmd_byte), .cmd_last(cmd_last), .tx_take(tx_take),
        .busy(busy), .ev_done(ev_done), .ev_ackerr(ev_ackerr),
        .ev_rs_done(ev_rs_done)
    );

    int checks = 0;
    int failures = 0;
    int log_q[$];
    int exp_q[$];
    int nack_at = -1;
    int take_cnt = 0;
    int done_cnt = 0;
    int rs_cnt = 0;
    int wcnt = 0;
    int seen = 0;
    bit clr_req = 1'b0;
    bit took = 1'b0;
    bit finished = 1'b0;

    localparam int EV_ACKERR = 9001;
    localparam int EV_RS     = 9002;
    localparam int EV_DONE   = 9003;

    function automatic int code(int op, int last, int b);
        return op * 1000 + last * 500 + b;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // engine model and event monitor; owns log_q and tx_byte
    initial begin
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            eng_nack = 1'b0;
            if (clr_req) begin
                log_q.delete();
                wcnt = 0; take_cnt = 0; seen = 0; took = 1'b0;
                tx_byte = 8'hA0;
                clr_req = 1'b0;
            end
            if (took) begin
                tx_byte = tx_byte + 8'd1;
                took = 1'b0;
            end
            if (rst_n && cmd_valid) begin
                seen++;
                if (seen >= 2) begin
                    log_q.push_back(code(int'(cmd_op), int'(cmd_last), int'(cmd_byte)));
                    if (cmd_op == 3'd3) begin
                        if (wcnt == nack_at) eng_nack = 1'b1;
                        wcnt++;
                    end
                    eng_done = 1'b1;
                    seen = 0;
                end
            end else begin
                seen = 0;
            end
            #1;
            if (tx_take) begin took = 1'b1; take_cnt++; end
            if (ev_ackerr) log_q.push_back(EV_ACKERR);
            if (ev_rs_done) begin log_q.push_back(EV_RS); rs_cnt++; end
            if (ev_done) begin log_q.push_back(EV_DONE); done_cnt++; end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=0 expected=1");
        summary();
    end

    task automatic clear();
        @(negedge clk);
        clr_req = 1'b1;
        nack_at = -1;
        exp_q.delete();
        @(negedge clk);
        #1;
    endtask

    task automatic launch(input bit multi, input bit more);
        @(negedge clk);
        start_go = 1'b1; start_multi = multi; start_more = more;
        @(negedge clk);
        start_go = 1'b0; start_multi = 1'b0; start_more = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int d0 = done_cnt;
        int k = 0;
        while (done_cnt == d0 && k < 5000) begin
            @(negedge clk);
            k++;
        end
        chk(k < 5000, {tag, " completion"}, k, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_log(input string tag, input int takes);
        int n;
        chk(log_q.size() == exp_q.size(), {tag, " stream length"}, log_q.size(), exp_q.size());
        n = (log_q.size() < exp_q.size()) ? log_q.size() : exp_q.size();
        for (int i = 0; i < n; i++) begin
            chk(log_q[i] == exp_q[i], $sformatf("%s item %0d", tag, i), log_q[i], exp_q[i]);
        end
        chk(take_cnt == takes, {tag, " tx_take count"}, take_cnt, takes);
    endtask

    task automatic e_wr(input int first_op, input int addr, input int n, input int base);
        exp_q.push_back(code(first_op, 0, 0));
        exp_q.push_back(code(3, 0, addr));
        for (int k = 0; k < n; k++) exp_q.push_back(code(3, 0, base + k));
    endtask

    task automatic e_rd(input int first_op, input int addr, input int n);
        exp_q.push_back(code(first_op, 0, 0));
        exp_q.push_back(code(3, 0, addr));
        for (int k = 0; k < n; k++) exp_q.push_back(code(4, (k == n - 1) ? 1 : 0, 0));
    endtask

    task automatic e_stop_done();
        exp_q.push_back(code(2, 0, 0));
        exp_q.push_back(EV_DONE);
    endtask

    task automatic setup(input int op, input int addr, input int lw, input int lr,
                         input int cnt, input bit rs);
        op_mode = 2'(op); addr_byte = 8'(addr); len_wr = 8'(lw);
        len_rd = 8'(lr); xact_count = 8'(cnt); ctrl_rs = rs;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1;
        chk(busy == 1'b0 && cmd_valid == 1'b0, "R1 reset idle", int'(busy), 0);
        chk({ev_done, ev_ackerr, ev_rs_done} == 3'b000, "R1 reset events", int'({ev_done, ev_ackerr, ev_rs_done}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 plain write of two bytes
        clear(); setup(1, 'hA4, 2, 0, 1, 0);
        e_wr(0, 'hA4, 2, 'hA0); e_stop_done();
        launch(0, 0); wait_done("R2 write");
        check_log("R2 write", 2);
        chk(busy == 1'b0, "R1 idle after done", int'(busy), 0);

        // R2 zero length: address only
        clear(); setup(0, 'hA4, 0, 0, 1, 0);
        e_wr(0, 'hA4, 0, 'hA0); e_stop_done();
        launch(0, 0); wait_done("R2 zero length");
        check_log("R2 zero length", 0);

        // R3 plain read of three bytes
        clear(); setup(2, 'hA5, 3, 0, 1, 0);
        e_rd(0, 'hA5, 3); e_stop_done();
        launch(0, 0); wait_done("R3 read");
        check_log("R3 read", 0);

        // R4 two writes joined by repeated start
        clear(); setup(1, 'hA4, 1, 0, 2, 1);
        e_wr(0, 'hA4, 1, 'hA0); e_wr(1, 'hA4, 1, 'hA1); e_stop_done();
        launch(0, 0); wait_done("R4 rs join");
        check_log("R4 rs join", 2);

        // R4 two writes joined by stop and start
        clear(); setup(1, 'hA4, 1, 0, 2, 0);
        e_wr(0, 'hA4, 1, 'hA0); exp_q.push_back(code(2, 0, 0));
        e_wr(0, 'hA4, 1, 'hA1); e_stop_done();
        launch(0, 0); wait_done("R4 stop join");
        check_log("R4 stop join", 2);

        // R5 combined, read length clamped to 31, repeated start
        clear(); setup(3, 'hA4, 1, 40, 1, 1);
        e_wr(0, 'hA4, 1, 'hA0); e_rd(1, 'hA5, 31); e_stop_done();
        launch(0, 0); wait_done("R5 combined rs");
        check_log("R5 combined rs", 1);

        // R5 combined with stop join, count input ignored
        clear(); setup(3, 'h50, 2, 2, 5, 0);
        e_wr(0, 'h50, 2, 'hA0); exp_q.push_back(code(2, 0, 0));
        e_rd(0, 'h51, 2); e_stop_done();
        launch(0, 0); wait_done("R5 combined stop");
        check_log("R5 combined stop", 2);

        // R6 nack on address
        clear(); setup(1, 'hA4, 3, 0, 1, 0); nack_at = 0;
        exp_q.push_back(code(0, 0, 0)); exp_q.push_back(code(3, 0, 'hA4));
        exp_q.push_back(EV_ACKERR); e_stop_done();
        launch(0, 0); wait_done("R6 nack addr");
        check_log("R6 nack addr", 0);

        // R6 nack on second data byte
        clear(); setup(1, 'hA4, 3, 0, 2, 1); nack_at = 2;
        e_wr(0, 'hA4, 2, 'hA0); exp_q.push_back(EV_ACKERR); e_stop_done();
        launch(0, 0); wait_done("R6 nack data");
        check_log("R6 nack data", 2);

        // R7 re-trigger with pause, then a final transaction with new address and length
        clear(); setup(1, 'hA4, 1, 0, 1, 0);
        e_wr(0, 'hA4, 1, 'hA0); exp_q.push_back(EV_RS);
        e_wr(1, 'hB0, 2, 'hA1); e_stop_done();
        begin
            int r0 = rs_cnt;
            int k = 0;
            launch(1, 1);
            while (rs_cnt == r0 && k < 5000) begin @(negedge clk); k++; end
            repeat (5) @(negedge clk);
            #1;
            chk(busy == 1'b1 && cmd_valid == 1'b0, "R7 paused holding bus", int'(cmd_valid), 0);
            addr_byte = 8'hB0; len_wr = 8'd2;
            launch(1, 0);
        end
        wait_done("R7 retrigger");
        check_log("R7 retrigger", 3);

        // R6/R7 coincidence: nack on last byte while more work is flagged
        clear(); setup(1, 'hA4, 1, 0, 1, 0); nack_at = 1;
        e_wr(0, 'hA4, 1, 'hA0); exp_q.push_back(EV_ACKERR); e_stop_done();
        launch(1, 1); wait_done("R6 R7 nack last");
        check_log("R6 R7 nack last", 1);

        // R8 strobe during a running transaction is ignored
        clear(); setup(1, 'hA4, 2, 0, 1, 0);
        e_wr(0, 'hA4, 2, 'hA0); e_stop_done();
        launch(0, 0);
        repeat (3) @(negedge clk);
        addr_byte = 8'h22; len_wr = 8'd7;
        launch(1, 1);
        wait_done("R8 busy strobe");
        check_log("R8 busy strobe", 2);

        // R8 no start without the go bit
        clear(); setup(1, 'hA4, 2, 0, 1, 0);
        @(negedge clk); start_multi = 1'b1; start_more = 1'b1;
        @(negedge clk); start_multi = 1'b0; start_more = 1'b0;
        repeat (20) @(negedge clk);
        #1;
        chk(busy == 1'b0, "R8 no go bit busy", int'(busy), 0);
        chk(log_q.size() == 0, "R8 no go bit stream", log_q.size(), 0);

        summary();
    end

endmodule